// File: doc/BRIEF.md
# Chained Barrel Issue Sequencer

This block picks the instruction that issues on each cycle of a barrel pipeline with `NSLOT` hardware slots. In normal operation the slots take turns in a fixed rotation, and each slot issues the head of its own fetch stream. A slot can instead run a chain-start instruction. Once that takes effect, the next `NCHAIN` slots in rotation give up their own streams. Each instruction the initiating slot issues is then replayed on those slots, one per cycle, against each slot's own register file. This gives SIMD-style replication under a single thread of control. A chain-end instruction from the initiator hands the borrowed slots back to their own streams after one dead cycle.

Each issued word tells the downstream pipeline six things: the target register-file index, the slot whose stream supplied the instruction, a slot identifier that software uses to split the work, whether this is a replayed copy, whether a branch redirect applies, and which slots are currently suspended. Fetch, decode, execution and the register files are outside the block. The fetch side is a per-slot valid/instruction pair, with a one-cycle acknowledge that the block raises when it consumes the head entry.

Top module: `chained_issue_seq`

## Requirements
- R1: After reset the turn pointer starts at slot 0 and advances by one slot per cycle, wrapping at `NSLOT`. On a turn that takes the slot's own stream, `fetch_ack` pulses for that slot in that cycle whenever its `fetch_valid` is high. The issued word appears on the `iss_*` outputs one cycle later, with `iss_rf` equal to the turn slot.
- R2: Each slot's `fetch_op` is 2 bits: 0 = plain, 1 = branch, 2 = chain start, 3 = chain end. A chain start taken while the block is idle issues as a valid instruction. The other slots keep issuing from their own streams until the turn returns to the initiator. From that turn onward the block is in chained mode.
- R3: In chained mode, the initiator's turn issues its own next instruction. On each of the next `NCHAIN` turns, that instruction issues again with `iss_replica` = 1, `iss_src_slot` = initiator and `iss_rf` = the turn slot. Slots further from the initiator than `NCHAIN` keep issuing their own streams.
- R4: A chained slot is never acknowledged on `fetch_ack` while chained. Every word issued in chained mode carries `suspend_mask` with exactly the chained slots set; at other times the mask is zero.
- R5: `iss_redirect` is high only for a branch taken from the issuing slot's own stream. A replayed branch never redirects.
- R6: `iss_slot_id` equals `ID_BASE` plus the target register-file index on every issued word.
- R7: A chain end from the initiator in chained mode issues as valid. The next cycle is a bubble (`iss_valid` = 0, `suspend_mask` = 0), and the turn pointer does not advance. Own-stream issue then resumes with the slot after the initiator.
- R8: A chain start taken while a chain is pending or active is consumed without issuing (`iss_valid` = 0). It raises that slot's `chain_err` bit for one word and leaves the chain state unchanged.
- R9: `iss_valid` is low on a turn whose slot has no fetch entry, and on a replayed copy whose initiator had no valid instruction to replay.
- R10: While reset is held, `iss_valid`, `iss_redirect`, `suspend_mask` and `chain_err` are all zero.
- R11: A chain end outside chained mode, or from a slot other than the initiator, issues as an ordinary instruction and has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | NSLOT | Per-slot fetch head valid |
| fetch_op | input | NSLOT x 2 | Per-slot head operation class |
| fetch_instr | input | NSLOT x IW | Per-slot head instruction word |
| fetch_ack | output | NSLOT | Per-slot head consumed this cycle |
| iss_valid | output | 1 | Issued word is a real instruction |
| iss_replica | output | 1 | Issued word is a replayed copy |
| iss_src_slot | output | SW | Slot whose stream supplied the instruction |
| iss_rf | output | SW | Target register-file index |
| iss_slot_id | output | IDW | Slot identifier sent with the instruction |
| iss_instr | output | IW | Instruction word |
| iss_redirect | output | 1 | Branch redirect applies to `iss_src_slot` |
| suspend_mask | output | NSLOT | Slots whose own streams are suspended |
| chain_err | output | NSLOT | One-cycle flag for a rejected chain start |

## Verification
The bench builds the block with four slots, two replicated slots and a non-zero identifier base. With that setting, one slot lies outside the chain while a chain is active. That slot's own issue, its branch redirects and its rejected chain starts can be observed next to the replayed copies, which the default full-width chain could never show. A behavioural reference model predicts the fetch acknowledges and every issued word each cycle. The stimulus covers idle rotation with empty slots, chain end outside a chain, a chain with replayed branches, an initiator whose first chained instruction is itself a rejected chain start, and an immediate release.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    OPC_PLAIN   = 2'd0,
    OPC_BRANCH  = 2'd1,
    OPC_CHAIN   = 2'd2,
    OPC_UNCHAIN = 2'd3
  } opc_t;

  typedef enum logic [1:0] {
    CM_IDLE  = 2'd0,
    CM_PEND  = 2'd1,
    CM_CHAIN = 2'd2
  } cmode_t;
endpackage

// File: rtl/cbi_rotor.sv
module cbi_rotor #(
  parameter int NSLOT = 4,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  output logic [SW-1:0] turn
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  always_ff @(posedge clk) begin
    if (rst)
      turn <= '0;
    else if (!hold)
      turn <= (turn == LAST) ? '0 : turn + 1'b1;
  end

  // R1
  rot_range_chk: assert property (@(posedge clk) disable iff (rst)
    turn <= LAST);
endmodule

// File: rtl/cbi_chain_ctl.sv
module cbi_chain_ctl import cbi_pkg::*; #(
  parameter int NSLOT  = 4,
  parameter int NCHAIN = 3,
  parameter int SW     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    cur,
  input  logic             start_evt,
  input  logic             end_evt,
  output cmode_t           mode,
  output logic [SW-1:0]    init,
  output logic             chain_now,
  output logic             member,
  output logic [NSLOT-1:0] mask
);
  logic pend_hit;

  assign pend_hit  = (mode == CM_PEND) && (cur == init);
  assign chain_now = (mode == CM_CHAIN) || pend_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= CM_IDLE;
      init <= '0;
    end else if (end_evt) begin
      mode <= CM_IDLE;
    end else if (start_evt) begin
      mode <= CM_PEND;
      init <= cur;
    end else if (pend_hit) begin
      mode <= CM_CHAIN;
    end
  end

  // Slots following the initiator in rotation, NCHAIN of them.
  always_comb begin
    mask = '0;
    for (int k = 1; k <= NCHAIN; k++) begin
      int idx;
      idx = int'(init) + k;
      if (idx >= NSLOT) idx = idx - NSLOT;
      mask[SW'(idx)] = 1'b1;
    end
  end

  assign member = chain_now && mask[cur];

  // R8
  init_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != CM_IDLE) && $past(mode != CM_IDLE) |-> $stable(init));

  // R2
  start_pend_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt && !end_evt |=> mode == CM_PEND);

  // R4
  init_not_member_chk: assert property (@(posedge clk) disable iff (rst)
    chain_now |-> !mask[init]);
endmodule

// File: rtl/cbi_replay.sv
module cbi_replay #(
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          vin,
  input  logic [IW-1:0] din,
  output logic          rep_v,
  output logic [IW-1:0] rep_i
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rep_v <= 1'b0;
      rep_i <= '0;
    end else if (load) begin
      rep_v <= vin;
      rep_i <= din;
    end
  end
endmodule

// File: rtl/chained_issue_seq.sv
module chained_issue_seq import cbi_pkg::*; #(
  parameter int NSLOT   = 4,
  parameter int NCHAIN  = NSLOT - 1,
  parameter int IW      = 32,
  parameter int IDW     = 8,
  parameter int ID_BASE = 0,
  localparam int SW     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSLOT-1:0]          fetch_valid,
  input  logic [NSLOT-1:0][1:0]     fetch_op,
  input  logic [NSLOT-1:0][IW-1:0]  fetch_instr,
  output logic [NSLOT-1:0]          fetch_ack,
  output logic                      iss_valid,
  output logic                      iss_replica,
  output logic [SW-1:0]             iss_src_slot,
  output logic [SW-1:0]             iss_rf,
  output logic [IDW-1:0]            iss_slot_id,
  output logic [IW-1:0]             iss_instr,
  output logic                      iss_redirect,
  output logic [NSLOT-1:0]          suspend_mask,
  output logic [NSLOT-1:0]          chain_err
);
  logic [SW-1:0]    cur;
  logic             bubble_q;
  cmode_t           mode;
  logic [SW-1:0]    init;
  logic             chain_now, member;
  logic [NSLOT-1:0] mask;
  logic             rep_v;
  logic [IW-1:0]    rep_i;

  logic             own_v;
  opc_t             own_op;
  logic [IW-1:0]    own_i;
  logic             take_own, at_init, is_start, is_endcmd, noop, consume;
  logic             start_evt, end_evt, rep_load, rep_vin;
  logic [NSLOT-1:0] err_d;

  cbi_rotor #(.NSLOT(NSLOT), .SW(SW)) u_rot (
    .clk(clk), .rst(rst), .hold(bubble_q), .turn(cur)
  );

  cbi_chain_ctl #(.NSLOT(NSLOT), .NCHAIN(NCHAIN), .SW(SW)) u_ctl (
    .clk(clk), .rst(rst), .cur(cur), .start_evt(start_evt), .end_evt(end_evt),
    .mode(mode), .init(init), .chain_now(chain_now), .member(member), .mask(mask)
  );

  cbi_replay #(.IW(IW)) u_rep (
    .clk(clk), .rst(rst), .load(rep_load), .vin(rep_vin), .din(own_i),
    .rep_v(rep_v), .rep_i(rep_i)
  );

  assign own_v     = fetch_valid[cur];
  assign own_op    = opc_t'(fetch_op[cur]);
  assign own_i     = fetch_instr[cur];
  assign take_own  = !bubble_q && !member;
  assign at_init   = (cur == init);
  assign is_start  = (own_op == OPC_CHAIN);
  assign is_endcmd = (own_op == OPC_UNCHAIN) && chain_now && at_init;
  assign noop      = is_start && (mode != CM_IDLE);
  assign consume   = take_own && own_v;
  assign start_evt = consume && is_start && (mode == CM_IDLE);
  assign end_evt   = consume && is_endcmd;
  assign rep_load  = take_own && chain_now && at_init;
  assign rep_vin   = own_v && !noop && !is_endcmd;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign fetch_ack[g] = consume && (cur == SW'(g));
    assign err_d[g]     = consume && noop && (cur == SW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bubble_q     <= 1'b0;
      iss_valid    <= 1'b0;
      iss_replica  <= 1'b0;
      iss_src_slot <= '0;
      iss_rf       <= '0;
      iss_slot_id  <= '0;
      iss_instr    <= '0;
      iss_redirect <= 1'b0;
      suspend_mask <= '0;
      chain_err    <= '0;
    end else begin
      bubble_q     <= end_evt;
      iss_valid    <= !bubble_q && (member ? rep_v : (own_v && !noop));
      iss_replica  <= !bubble_q && member;
      iss_src_slot <= member ? init : cur;
      iss_rf       <= cur;
      iss_slot_id  <= IDW'(ID_BASE) + IDW'(cur);
      iss_instr    <= member ? rep_i : own_i;
      iss_redirect <= consume && (own_op == OPC_BRANCH);
      suspend_mask <= (!bubble_q && chain_now) ? mask : '0;
      chain_err    <= err_d;
    end
  end

  // R1
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fetch_ack));

  // R4
  own_not_suspended_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_replica |-> !suspend_mask[iss_rf]);

  // R5
  replica_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    iss_replica |-> !iss_redirect);

  // R8
  err_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chain_err));

  // R7
  end_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> bubble_q);

  // R7
  bubble_out_chk: assert property (@(posedge clk) disable iff (rst)
    bubble_q |=> !iss_valid && (suspend_mask == '0));
endmodule

// File: tb/sim_chained_issue_seq.sv
module sim_chained_issue_seq;
  localparam int NS  = 4;
  localparam int NC  = 2;
  localparam int IW  = 16;
  localparam int IDW = 8;
  localparam int IDB = 16;
  localparam int SW  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst;

  logic [NS-1:0]         fv;
  logic [NS-1:0][1:0]    fop;
  logic [NS-1:0][IW-1:0] fin;
  logic [NS-1:0]         ack;
  logic                  o_valid, o_rep, o_redir;
  logic [SW-1:0]         o_src, o_rf;
  logic [IDW-1:0]        o_id;
  logic [IW-1:0]         o_instr;
  logic [NS-1:0]         o_susp, o_err;

  chained_issue_seq #(.NSLOT(NS), .NCHAIN(NC), .IW(IW), .IDW(IDW), .ID_BASE(IDB)) u0 (
    .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_op(fop), .fetch_instr(fin),
    .fetch_ack(ack), .iss_valid(o_valid), .iss_replica(o_rep), .iss_src_slot(o_src),
    .iss_rf(o_rf), .iss_slot_id(o_id), .iss_instr(o_instr), .iss_redirect(o_redir),
    .suspend_mask(o_susp), .chain_err(o_err)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [IW+1:0] q [NS][$];

  // reference model state
  int m_mode, m_init, m_turn;
  bit m_bub, m_rep_v;
  logic [IW-1:0] m_rep_i;

  // expected word for the next edge
  bit e_valid, e_rep, e_redir;
  int e_src, e_rf;
  logic [IW-1:0] e_instr;
  logic [NS-1:0] e_susp, e_err, e_ack;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] mask_of(input int ini);
    logic [NS-1:0] m = '0;
    for (int k = 1; k <= NC; k++) m[(ini + k) % NS] = 1'b1;
    return m;
  endfunction

  task automatic drive();
    for (int c = 0; c < NS; c++) begin
      if (q[c].size() > 0) begin
        fv[c] = 1'b1;
        {fop[c], fin[c]} = q[c][0];
      end else begin
        fv[c] = 1'b0; fop[c] = '0; fin[c] = '0;
      end
    end
  endtask

  task automatic push(input int s, input int op, input int ins);
    q[s].push_back({op[1:0], ins[IW-1:0]});
  endtask

  task automatic decide();
    int c, d, mm, op;
    logic [IW+1:0] ent;
    e_valid = 0; e_rep = 0; e_redir = 0; e_src = 0; e_rf = 0; e_instr = '0;
    e_susp = '0; e_err = '0; e_ack = '0; e_tag = "R1";
    if (m_bub) begin
      m_bub = 0;
      e_tag = "R7";
    end else begin
      c = m_turn;
      m_turn = (c + 1) % NS;
      mm = m_mode;
      if (mm == 1 && c == m_init) mm = 2;
      m_mode = mm;
      d = (c - m_init + NS) % NS;
      e_rf = c; e_src = c;
      e_susp = (mm == 2) ? mask_of(m_init) : '0;
      if (mm == 1) e_tag = "R2";
      if (mm == 2 && d >= 1 && d <= NC) begin
        e_rep = 1; e_src = m_init; e_valid = m_rep_v; e_instr = m_rep_i;
        e_tag = m_rep_v ? "R3" : "R9";
      end else if (q[c].size() > 0) begin
        ent = q[c][0];
        op = int'(ent[IW+1:IW]);
        e_instr = ent[IW-1:0];
        e_ack[c] = 1'b1;
        if (op == 2) begin
          if (mm == 0) begin
            e_valid = 1; m_mode = 1; m_init = c; e_tag = "R2";
          end else begin
            e_valid = 0; e_err[c] = 1'b1; e_tag = "R8";
          end
        end else if (op == 3 && mm == 2 && c == m_init) begin
          e_valid = 1; m_mode = 0; m_bub = 1; e_tag = "R7";
        end else begin
          e_valid = 1; e_redir = (op == 1);
          if (op == 3) e_tag = "R11";
          else if (op == 1) e_tag = "R5";
        end
        if (mm == 2 && c == m_init) begin
          m_rep_v = (op < 2);
          m_rep_i = ent[IW-1:0];
        end
      end else begin
        e_tag = "R9";
        if (mm == 2 && c == m_init) m_rep_v = 0;
      end
    end
    chk(ack == e_ack, "R4", "fetch_ack", ack, e_ack);
  endtask

  task automatic step();
    @(negedge clk);
    chk(o_valid == e_valid, e_tag, "iss_valid", o_valid, e_valid);
    if (e_valid) begin
      chk(o_rep == e_rep, "R3", "iss_replica", o_rep, e_rep);
      chk(o_src == SW'(e_src), "R3", "iss_src_slot", o_src, e_src);
      chk(o_rf == SW'(e_rf), "R1", "iss_rf", o_rf, e_rf);
      chk(o_id == IDW'(IDB + e_rf), "R6", "iss_slot_id", o_id, IDB + e_rf);
      chk(o_instr == e_instr, e_tag, "iss_instr", o_instr, e_instr);
    end
    chk(o_redir == e_redir, "R5", "iss_redirect", o_redir, e_redir);
    chk(o_susp == e_susp, "R4", "suspend_mask", o_susp, e_susp);
    chk(o_err == e_err, "R8", "chain_err", o_err, e_err);
    for (int c = 0; c < NS; c++) if (e_ack[c]) void'(q[c].pop_front());
    drive();
    #1;
    decide();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    fv = '0; fop = '0; fin = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(o_valid == 1'b0, "R10", "iss_valid", o_valid, 0);
    chk(o_redir == 1'b0, "R10", "iss_redirect", o_redir, 0);
    chk(o_susp == '0, "R10", "suspend_mask", o_susp, 0);
    chk(o_err == '0, "R10", "chain_err", o_err, 0);
    rst = 1'b0;
    m_mode = 0; m_init = 0; m_turn = 0; m_bub = 0; m_rep_v = 0; m_rep_i = '0;
    drive();
    #1;
    decide();

    // plain rotation, empty slot, chain end outside a chain (R1, R9, R11)
    push(0, 0, 16'h0001); push(0, 1, 16'h0002); push(0, 0, 16'h0003);
    push(1, 0, 16'h0101); push(1, 0, 16'h0102);
    push(2, 1, 16'h0201); push(2, 3, 16'h0202);
    run(16);

    // chain from slot 1 with an unchained slot and rejected starts (R2, R3, R4, R8)
    push(1, 2, 16'h1100); push(1, 0, 16'h1101); push(1, 1, 16'h1102);
    push(1, 0, 16'h1103); push(1, 3, 16'h1104); push(1, 0, 16'h1105);
    push(0, 0, 16'h1000); push(0, 2, 16'h1001); push(0, 1, 16'h1002); push(0, 0, 16'h1003);
    push(2, 0, 16'h1200); push(2, 0, 16'h1201); push(2, 0, 16'h1202);
    push(3, 0, 16'h1300); push(3, 3, 16'h1301); push(3, 0, 16'h1302);
    run(60);

    // chain from slot 3; first chained op is a rejected start, copies are bubbles (R8, R9)
    push(3, 2, 16'h2300); push(3, 2, 16'h2301); push(3, 1, 16'h2302); push(3, 3, 16'h2303);
    push(0, 0, 16'h2000); push(0, 0, 16'h2001);
    push(1, 0, 16'h2100); push(1, 0, 16'h2101);
    push(2, 1, 16'h2200); push(2, 0, 16'h2201);
    run(50);

    // immediate release from slot 2 (R7)
    push(2, 2, 16'h3200); push(2, 3, 16'h3201);
    push(3, 0, 16'h3300); push(0, 0, 16'h3000); push(1, 0, 16'h3100);
    run(30);

    // R7 every suspended stream resumed and drained
    for (int c = 0; c < NS; c++)
      chk(q[c].size() == 0, "R7", "queue_left", q[c].size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule